// File: doc/BRIEF.md
# Cascadable LCD Segment Column Latch

This block is the digital front end of an 80-column segment driver for a dot-matrix LCD. A controller supplies display data for one row at a time. The data arrives either as a serial bit stream on one pin or as 4-bit nibbles on four pins, and it is qualified by a data clock. Each nibble lands in one of twenty 4-bit groups of a fill latch, in group order. A load strobe then copies the fill latch into an output latch. The output latch sets the column pattern until the next load.

Several of these blocks can share one data bus in a daisy chain. The first block's enable input is tied low. Every block passes its active-low enable output to the next block's enable input. A block accepts data only while its enable input is low and it has not yet been filled. After its twentieth nibble it ignores further clocks and pulls its enable output low, which hands the bus to the next block. The load strobe re-arms every block for the next row.

Each column output is a 2-bit drive-level code. The code is built from the stored data bit, the frame-alternation input and a display-off input.

Top module: `lcd_seg_latch`

## Requirements
- R1: After reset both latches are zero, the address is at group 0, and `en_out` is 1. With `frame_m`=0 and `disp_off`=0, every `lvl` code is 2'b00.
- R2: In parallel mode (`ser_sel`=0), `pdin` is sampled on the clock after `dclk` is seen to fall, not while `dclk` is high. The sampled value is written to the current group g, with `pdin[k]` going to column 4*g+k, and the group address then advances by one.
- R3: In serial mode (`ser_sel`=1), one `sdin` bit is sampled on each `dclk` fall. Every four bits form a nibble, sent MSB first, so the first bit of group g lands in column 4*g+3 and the fourth bit lands in column 4*g. Only a completed nibble is written.
- R4: Serial bits left over after the last complete nibble are never written. A load discards them, and the next row starts with a fresh nibble.
- R5: After the twentieth nibble of a row, `en_out` goes low in the same cycle as that write, and later `dclk` falls change no column.
- R6: While `en_in` is 1, `dclk` falls write nothing and `en_out` stays 1.
- R7: On the first clock cycle in which `load` is seen high after being low, the fill latch is copied to the output latch. In that same cycle the address returns to group 0 and `en_out` returns to 1. A `dclk` fall in the same cycle is discarded.
- R8: Writes to the fill latch do not change `lvl` until the next load.
- R9: With `disp_off`=0, the code of column c is `lvl[2c+1:2c]` = {bit XOR `frame_m`, `frame_m`}, where bit is the stored data bit of column c.
- R10: With `disp_off`=1, every column shows {`frame_m`, `frame_m`}, which is the not-selected code for the current frame, whatever data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it samples every other input |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_sel | input | 1 | 1 = serial input on `sdin`, 0 = nibble input on `pdin` |
| dclk | input | 1 | Data clock; data is taken when it falls |
| sdin | input | 1 | Serial data bit |
| pdin | input | 4 | Parallel data nibble |
| load | input | 1 | Row load strobe; acts on its rising edge |
| en_in | input | 1 | Chain enable in, active low |
| frame_m | input | 1 | Frame alternation signal |
| disp_off | input | 1 | Forces all columns to the not-selected code |
| en_out | output | 1 | Chain enable out, active low once the block is filled |
| lvl | output | 160 | Two-bit drive code per column, column c at bits [2c+1:2c] |

## Verification
A `dclk` fall takes effect on the `clk` edge that first sees `dclk` low. A fill-latch write and the `en_out` change after the twentieth nibble both become visible right after that edge. A load copies the latches on the first edge that sees `load` high. `lvl` follows the output latch, `frame_m` and `disp_off` without a register stage. The bench drives every input at a falling `clk` edge and keeps each `dclk` and `load` level for a full cycle. It samples one falling edge later, after exactly one rising edge has acted. Changes to `frame_m` and `disp_off` are checked at the next falling edge.

// File: rtl/lcd_seg_pkg.sv
`timescale 1ns/1ps
package lcd_seg_pkg;

  typedef logic [1:0] lvl_t;

  // Drive code for one column: bit 1 says selected (data differs from frame),
  // bit 0 carries the frame phase. Blanking keeps bit 1 equal to the frame.
  function automatic lvl_t lvl_code(input logic dat, input logic m, input logic off);
    lvl_t r;
    r[0] = m;
    r[1] = off ? m : (dat ^ m);
    return r;
  endfunction

  // Lowest column index of a group.
  function automatic int unsigned grp_base(input int unsigned g, input int unsigned nib);
    return g * nib;
  endfunction

  // True when the given address is the final group of a row.
  function automatic logic is_last_grp(input int unsigned addr, input int unsigned ngrp);
    return addr == (ngrp - 1);
  endfunction

endpackage

// File: rtl/lsl_input.sv
`timescale 1ns/1ps
module lsl_input #(
  parameter int NIB = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_sel,
  input  logic           dclk,
  input  logic           sdin,
  input  logic [NIB-1:0] pdin,
  input  logic           load,
  input  logic           accept,
  output logic           dclk_fall,
  output logic           load_rise,
  output logic           nib_valid,
  output logic [NIB-1:0] nib_data
);
  localparam int CW = (NIB > 1) ? $clog2(NIB) : 1;
  localparam logic [CW-1:0] LAST = CW'(NIB - 1);

  logic           dclk_q;
  logic           load_q;
  logic [NIB-2:0] hold;
  logic [CW-1:0]  bitcnt;
  logic [NIB-1:0] shifted;
  logic           take_bit;

  assign dclk_fall = dclk_q & ~dclk;
  assign load_rise = load & ~load_q;
  assign take_bit  = dclk_fall & accept & ~load_rise;
  assign shifted   = {hold, sdin};
  assign nib_data  = ser_sel ? shifted : pdin;
  assign nib_valid = take_bit & (~ser_sel | (bitcnt == LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_q <= 1'b0;
      load_q <= 1'b0;
      hold   <= '0;
      bitcnt <= '0;
    end else begin
      dclk_q <= dclk;
      load_q <= load;
      if (load_rise) begin
        bitcnt <= '0;
        hold   <= '0;
      end else if (take_bit) begin
        if (!ser_sel) begin
          bitcnt <= '0;
        end else begin
          hold   <= shifted[NIB-2:0];
          bitcnt <= (bitcnt == LAST) ? '0 : bitcnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lsl_addr_ctrl.sv
`timescale 1ns/1ps
module lsl_addr_ctrl
  import lcd_seg_pkg::*;
#(
  parameter int NGRP = 20,
  parameter int AW   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_in,
  input  logic          load_rise,
  input  logic          nib_valid,
  output logic          accept,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          full,
  output logic          en_out
);
  assign accept = ~en_in & ~full;
  assign wr_en  = nib_valid;
  assign en_out = ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr <= '0;
      full    <= 1'b0;
    end else if (load_rise) begin
      wr_addr <= '0;
      full    <= 1'b0;
    end else if (wr_en) begin
      wr_addr <= wr_addr + AW'(1);
      if (is_last_grp(int'(wr_addr), NGRP)) full <= 1'b1;
    end
  end
endmodule

// File: rtl/lsl_latch_pair.sv
`timescale 1ns/1ps
module lsl_latch_pair
  import lcd_seg_pkg::*;
#(
  parameter int NCOL = 80,
  parameter int NIB  = 4,
  parameter int AW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [NIB-1:0]  nib_data,
  input  logic            load_rise,
  output logic [NCOL-1:0] lat2
);
  localparam int NGRP = NCOL / NIB;

  logic [NCOL-1:0] lat1;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int BASE = grp_base(g, NIB);
    logic sel;
    assign sel = wr_en && (wr_addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lat1[BASE +: NIB] <= '0;
      else if (sel) lat1[BASE +: NIB] <= nib_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lat2 <= '0;
    else if (load_rise) lat2 <= lat1;
  end
endmodule

// File: rtl/lsl_level_enc.sv
`timescale 1ns/1ps
module lsl_level_enc
  import lcd_seg_pkg::*;
#(
  parameter int NCOL = 80
) (
  input  logic [NCOL-1:0]   lat2,
  input  logic              frame_m,
  input  logic              disp_off,
  output logic [2*NCOL-1:0] lvl
);
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign lvl[2*c +: 2] = lvl_code(lat2[c], frame_m, disp_off);
  end
endmodule

// File: rtl/lcd_seg_latch.sv
`timescale 1ns/1ps
module lcd_seg_latch #(
  parameter int NCOL = 80,
  parameter int NIB  = 4,
  parameter int AW   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_sel,
  input  logic              dclk,
  input  logic              sdin,
  input  logic [NIB-1:0]    pdin,
  input  logic              load,
  input  logic              en_in,
  input  logic              frame_m,
  input  logic              disp_off,
  output logic              en_out,
  output logic [2*NCOL-1:0] lvl
);
  localparam int NGRP = NCOL / NIB;

  // Internal events, named so that the checker can observe them.
  logic            dclk_fall;
  logic            load_rise;
  logic            nib_valid;
  logic [NIB-1:0]  nib_data;
  logic            accept;
  logic            wr_en;
  logic [AW-1:0]   wr_addr;
  logic            full;
  logic [NCOL-1:0] lat2;

  lsl_input #(.NIB(NIB)) u_in (
    .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .dclk(dclk), .sdin(sdin),
    .pdin(pdin), .load(load), .accept(accept), .dclk_fall(dclk_fall),
    .load_rise(load_rise), .nib_valid(nib_valid), .nib_data(nib_data)
  );

  lsl_addr_ctrl #(.NGRP(NGRP), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en_in(en_in), .load_rise(load_rise),
    .nib_valid(nib_valid), .accept(accept), .wr_en(wr_en),
    .wr_addr(wr_addr), .full(full), .en_out(en_out)
  );

  lsl_latch_pair #(.NCOL(NCOL), .NIB(NIB), .AW(AW)) u_lat (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .nib_data(nib_data), .load_rise(load_rise), .lat2(lat2)
  );

  lsl_level_enc #(.NCOL(NCOL)) u_enc (
    .lat2(lat2), .frame_m(frame_m), .disp_off(disp_off), .lvl(lvl)
  );
endmodule

// File: rtl/lcd_seg_latch_chk.sv
`timescale 1ns/1ps
module lcd_seg_latch_chk #(
  parameter int NCOL = 80,
  parameter int NIB  = 4,
  parameter int AW   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_in,
  input logic              frame_m,
  input logic              disp_off,
  input logic              en_out,
  input logic [2*NCOL-1:0] lvl,
  input logic              load_rise,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic              full,
  input logic [NCOL-1:0]   lat2
);
  localparam int NGRP = NCOL / NIB;

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wr_addr == $past(wr_addr) + AW'(1));

  // R5
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_en);

  // R5
  hand_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(NGRP - 1)) |=> !en_out);

  // R6
  chain_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_in |-> !wr_en);

  // R7
  load_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_rise |=> (wr_addr == '0) && en_out);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_rise |=> $stable(lat2));

  // R9
  col0_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_off |-> (lvl[0] == frame_m) && (lvl[1] == (lat2[0] != frame_m)));

  // R10
  blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_off |-> lvl == {NCOL{frame_m, frame_m}});
endmodule

bind lcd_seg_latch lcd_seg_latch_chk #(.NCOL(NCOL), .NIB(NIB), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_in(en_in), .frame_m(frame_m),
  .disp_off(disp_off), .en_out(en_out), .lvl(lvl), .load_rise(load_rise),
  .wr_en(wr_en), .wr_addr(wr_addr), .full(full), .lat2(lat2)
);

// File: tb/tb_lcd_seg_latch.sv
`timescale 1ns/1ps
module tb_lcd_seg_latch;
  localparam int NCOL = 80;
  localparam int NIB  = 4;
  localparam int NGRP = NCOL / NIB;

  typedef struct packed {
    logic            ser;
    logic            m;
    logic            off;
    logic [NCOL-1:0] pat;
  } row_t;

  localparam row_t ROWS [6] = '{
    '{1'b0, 1'b0, 1'b0, 80'h0123456789ABCDEF0F1E},
    '{1'b1, 1'b1, 1'b0, 80'hFEDCBA9876543210A55A},
    '{1'b0, 1'b1, 1'b1, 80'hFFFFFFFFFFFFFFFFFFFF},
    '{1'b1, 1'b0, 1'b1, 80'h5A5A5A5A5A5A5A5A5A5A},
    '{1'b0, 1'b1, 1'b0, 80'h80000000000000000001},
    '{1'b1, 1'b0, 1'b0, 80'hC3C30000FFFF12348421}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              ser_sel = 1'b0, dclk = 1'b0, sdin = 1'b0, load = 1'b0;
  logic [NIB-1:0]    pdin = '0;
  logic              en_in = 1'b0, frame_m = 1'b0, disp_off = 1'b0;
  logic              en_out;
  logic [2*NCOL-1:0] lvl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  lcd_seg_latch dut (
    .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .dclk(dclk), .sdin(sdin),
    .pdin(pdin), .load(load), .en_in(en_in), .frame_m(frame_m),
    .disp_off(disp_off), .en_out(en_out), .lvl(lvl)
  );

  // Expected column codes, built from the requirement wording.
  function automatic logic [2*NCOL-1:0] exp_lvl(logic [NCOL-1:0] p, logic m, logic off);
    logic [2*NCOL-1:0] r;
    for (int c = 0; c < NCOL; c++) begin
      r[2*c]   = m;
      r[2*c+1] = off ? m : (p[c] != m);
    end
    return r;
  endfunction

  task automatic chk_lvl(string req, logic [NCOL-1:0] p);
    logic [2*NCOL-1:0] e;
    e = exp_lvl(p, frame_m, disp_off);
    checks++;
    if (lvl !== e) begin
      errors++;
      $display("FAIL %s lvl=%h exp=%h", req, lvl, e);
    end
  endtask

  task automatic chk_en(string req, logic e);
    checks++;
    if (en_out !== e) begin
      errors++;
      $display("FAIL %s en_out=%b exp=%b", req, en_out, e);
    end
  endtask

  // One data-clock period; the data is wrong while dclk is high and right at its fall.
  task automatic pulse(logic [NIB-1:0] pv, logic sb);
    @(negedge clk); dclk = 1'b1; pdin = ~pv; sdin = ~sb;
    @(negedge clk); pdin = pv; sdin = sb;
    @(negedge clk); dclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_nib(logic [NIB-1:0] v);
    if (ser_sel) begin
      for (int b = NIB - 1; b >= 0; b--) pulse('0, v[b]);
    end else begin
      pulse(v, 1'b0);
    end
  endtask

  task automatic send_line(logic [NCOL-1:0] p);
    for (int g = 0; g < NGRP; g++) send_nib(p[NIB*g +: NIB]);
  endtask

  task automatic do_load();
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, got timeout exp completion");
      finish_run();
    end
  end

  initial begin
    logic [NCOL-1:0] shown;
    logic [NCOL-1:0] q;
    logic [NCOL-1:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk_lvl("R1", '0);
    chk_en("R1", 1'b1);
    shown = '0;

    // Table of rows: fill, check hand-over, load, check codes.
    for (int i = 0; i < 6; i++) begin
      frame_m = 1'b0; disp_off = 1'b0;
      ser_sel = ROWS[i].ser;
      send_line(ROWS[i].pat);
      // R8: outputs still show the previous row
      chk_lvl("R8", shown);
      // R5: enable handed over after the twentieth nibble
      chk_en("R5", 1'b0);
      do_load();
      // R7: re-armed
      chk_en("R7", 1'b1);
      frame_m = ROWS[i].m; disp_off = ROWS[i].off;
      @(negedge clk);
      // R2 (parallel rows), R3 (serial rows), R9, R10 by row settings
      chk_lvl(ROWS[i].ser ? "R3/R9/R10" : "R2/R9/R10", ROWS[i].pat);
      shown = ROWS[i].pat;
    end
    frame_m = 1'b0; disp_off = 1'b0;

    // R8: partial fill leaves outputs alone
    ser_sel = 1'b0;
    q = 80'h13579BDF02468ACE1122;
    for (int g = 0; g < 5; g++) send_nib(q[NIB*g +: NIB]);
    chk_lvl("R8", shown);
    for (int g = 5; g < NGRP; g++) send_nib(q[NIB*g +: NIB]);
    // R5: extra clocks after full are ignored
    for (int g = 0; g < 3; g++) send_nib(4'hF);
    chk_en("R5", 1'b0);
    do_load();
    chk_lvl("R5", q);
    shown = q;

    // R6: chain enable high blocks writes
    en_in = 1'b1;
    send_line(80'hAAAA5555AAAA5555AAAA);
    chk_en("R6", 1'b1);
    do_load();
    chk_lvl("R6", shown);
    en_in = 1'b0;

    // R4: three serial nibbles plus two stray bits, then load
    ser_sel = 1'b1;
    r = 80'h0F0F0F0F0F0F0F0F0F0F;
    for (int g = 0; g < 3; g++) send_nib(r[NIB*g +: NIB]);
    pulse('0, 1'b1);
    pulse('0, 1'b1);
    do_load();
    chk_lvl("R4", {shown[NCOL-1:12], r[11:0]});
    // R4: next row starts on a nibble boundary
    r = 80'h9876543210FEDCBA0369;
    send_line(r);
    chk_en("R4", 1'b0);
    do_load();
    chk_lvl("R4", r);

    // R10 with frame high, then R9 with frame high
    disp_off = 1'b1; frame_m = 1'b1;
    @(negedge clk);
    chk_lvl("R10", r);
    disp_off = 1'b0;
    @(negedge clk);
    chk_lvl("R9", r);

    finish_run();
  end
endmodule